// File: doc/BRIEF.md
# Vector Memory Address Generator

This block turns one vector memory instruction into a stream of per-element effective addresses. A single start pulse captures an addressing mode, a scalar base, a scalar stride and a vector length. The block then presents one request per element, carrying the element number and its address, on a valid/ready stream. Three modes share one sequencer. In unit-stride mode the elements sit in adjacent memory words. In strided mode consecutive elements are a fixed distance apart. In indexed mode each address is the base plus an index value taken from a separate index stream, which is how a gather or a scatter is addressed.

Addresses count in elements, so unit-stride is the same as a stride of one. Loads and stores, and gathers and scatters, see the same address sequence, because only the direction of the later data transfer differs. Only the first VL elements are issued. A one-cycle done pulse follows the final accepted request. A zero length gives done straight away and issues nothing.

Top module: `vec_agen`

## Requirements
- R1: While reset is asserted and after it is released with no start, req_valid_o, done_o and idx_ready_o are all low.
- R2: Mode code 0 (unit-stride): element i carries address base + i. The first request is valid in the cycle after the clock edge that samples start_i.
- R3: Mode code 1 (strided): element i carries address base + i*stride, taken modulo 2^ADDR_W, so the sequence wraps past the top of the address space.
- R4: Mode code 2 (indexed): each request carries base + the index value accepted for that element, in the order the indices were accepted. idx_ready_o is high only during an indexed run while no request is pending. A request becomes valid in the cycle after its index is accepted.
- R5: A run with length VL issues exactly VL requests, numbered 0 to VL-1 in order.
- R6: While req_valid_o is high and req_ready_i is low, the request stays valid and its address and element number do not change.
- R7: done_o is high for exactly one cycle: the cycle after the edge that accepts the final request. It is never high together with req_valid_o. After it, no request and no index handshake occurs until the next start.
- R8: A start with VL = 0 raises done_o in the next cycle and issues no request.
- R9: A start pulse that arrives during a run, or during the done cycle, is ignored. The run in progress continues with its original base, stride and length, and no second run follows.
- R10: Mode code 3 behaves like unit-stride.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a run; sampled only when idle |
| mode_i | input | 2 | Addressing mode: 0 unit, 1 strided, 2 indexed, 3 as unit |
| base_i | input | ADDR_W | Scalar base address in element units |
| stride_i | input | ADDR_W | Scalar stride in element units (strided mode) |
| vl_i | input | VL_W | Number of elements to issue |
| idx_valid_i | input | 1 | Index value available |
| idx_data_i | input | ADDR_W | Index value for the next element |
| idx_ready_o | output | 1 | Generator takes an index this cycle |
| req_valid_o | output | 1 | Address request valid |
| req_ready_i | input | 1 | Consumer accepts the request |
| req_elem_o | output | VL_W | Element number of the request |
| req_addr_o | output | ADDR_W | Effective address of the request |
| done_o | output | 1 | One-cycle pulse after the last request |

## Verification
Each result has a fixed delay after its stimulus. The first unit or strided request is due one edge after start is sampled. An indexed request is due one edge after its index handshake. done is due one edge after the final request handshake, or one edge after a zero-length start. The bench drives inputs and samples outputs on the falling clock edge. At each falling edge it first reads the state left by the previous rising edge, checks that state against the delay it expects, and only then sets the ready and index inputs for the next rising edge. Any handshake the bench scores is therefore one it has just set up for the coming edge. The sweep covers every mode code, lengths 0 to 17, several strides including a wrapping one, and both an always-ready consumer and a pseudo-random stalling consumer with a stalling index source.

// File: rtl/vec_agen_pkg.sv
`timescale 1ns/1ps
package vec_agen_pkg;
  typedef enum logic [1:0] {
    AM_UNIT   = 2'd0,
    AM_STRIDE = 2'd1,
    AM_INDEX  = 2'd2,
    AM_SPARE  = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_FIN  = 2'd2
  } seq_e;
endpackage

// File: rtl/vec_agen_seq.sv
`timescale 1ns/1ps
module vec_agen_seq
  import vec_agen_pkg::*;
#(
  parameter int VL_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [VL_W-1:0] vl_i,
  input  logic            hs_i,
  output logic            launch_o,
  output logic            run_o,
  output logic            last_o,
  output logic [VL_W-1:0] elem_o,
  output logic            done_o
);
  localparam logic [VL_W-1:0] ONE_E = VL_W'(1);

  seq_e            state_q, state_d;
  logic [VL_W-1:0] elem_q, elem_d;
  logic [VL_W-1:0] vl_q, vl_d;
  logic            accept;
  logic            cnt_en;

  assign accept   = (state_q == SQ_IDLE) && start_i;
  assign launch_o = accept && (vl_i != '0);
  assign run_o    = (state_q == SQ_RUN);
  assign last_o   = (elem_q == (vl_q - ONE_E));
  assign elem_o   = elem_q;
  assign done_o   = (state_q == SQ_FIN);

  always_comb begin
    state_d = state_q;
    elem_d  = elem_q;
    vl_d    = vl_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (start_i) begin
          cnt_en  = 1'b1;
          elem_d  = '0;
          vl_d    = vl_i;
          state_d = (vl_i == '0) ? SQ_FIN : SQ_RUN;
        end
      end
      SQ_RUN: begin
        if (hs_i) begin
          if (last_o) begin
            state_d = SQ_FIN;
          end else begin
            cnt_en = 1'b1;
            elem_d = elem_q + ONE_E;
          end
        end
      end
      SQ_FIN:  state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem_q <= '0;
      vl_q   <= '0;
    end else if (cnt_en) begin
      elem_q <= elem_d;
      vl_q   <= vl_d;
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && hs_i && last_o) |=> done_o);

  // R8
  zero_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (vl_i == '0)) |=> (done_o && !run_o));

  // R5
  elem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_o |-> (elem_q < vl_q));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && start_i && !hs_i) |=> ($stable(vl_q) && $stable(elem_q)));
endmodule

// File: rtl/vec_agen_addr.sv
`timescale 1ns/1ps
module vec_agen_addr
  import vec_agen_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  amode_e            mode_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic              run_i,
  input  logic              hs_i,
  input  logic              last_i,
  input  logic              idx_valid_i,
  input  logic [ADDR_W-1:0] idx_data_i,
  output logic              idx_ready_o,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] UNIT_STEP = ADDR_W'(1);

  logic              indexed_q;
  logic [ADDR_W-1:0] base_q, step_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              valid_q, valid_d;
  logic              idx_take;
  logic              addr_en;

  assign idx_ready_o = run_i && indexed_q && !valid_q;
  assign idx_take    = idx_ready_o && idx_valid_i;
  assign valid_o     = valid_q;
  assign addr_o      = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      indexed_q <= 1'b0;
      base_q    <= '0;
      step_q    <= '0;
    end else if (launch_i) begin
      indexed_q <= (mode_i == AM_INDEX);
      base_q    <= base_i;
      step_q    <= (mode_i == AM_STRIDE) ? stride_i : UNIT_STEP;
    end
  end

  always_comb begin
    addr_d  = addr_q;
    valid_d = valid_q;
    addr_en = 1'b0;
    if (launch_i) begin
      addr_en = 1'b1;
      addr_d  = base_i;
      valid_d = (mode_i != AM_INDEX);
    end else if (hs_i) begin
      addr_en = 1'b1;
      addr_d  = addr_q + step_q;
      valid_d = !(last_i || indexed_q);
    end else if (idx_take) begin
      addr_en = 1'b1;
      addr_d  = base_q + idx_data_i;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else if (addr_en) begin
      addr_q  <= addr_d;
      valid_q <= valid_d;
    end
  end

  // R6
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !hs_i) |=> (valid_q && $stable(addr_q)));

  // R4
  idx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ready_o |-> !valid_q);

  // R4
  idx_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_take |=> valid_q);

  // R4
  idx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_i && indexed_q) |=> !valid_q);
endmodule

// File: rtl/vec_agen.sv
`timescale 1ns/1ps
module vec_agen
  import vec_agen_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int VL_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic              idx_valid_i,
  input  logic [ADDR_W-1:0] idx_data_i,
  output logic              idx_ready_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [VL_W-1:0]   req_elem_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic              done_o
);
  logic launch, run, last, hs;

  assign hs = req_valid_o && req_ready_i;

  vec_agen_seq #(.VL_W(VL_W)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .vl_i     (vl_i),
    .hs_i     (hs),
    .launch_o (launch),
    .run_o    (run),
    .last_o   (last),
    .elem_o   (req_elem_o),
    .done_o   (done_o)
  );

  vec_agen_addr #(.ADDR_W(ADDR_W)) addr_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch_i    (launch),
    .mode_i      (amode_e'(mode_i)),
    .base_i      (base_i),
    .stride_i    (stride_i),
    .run_i       (run),
    .hs_i        (hs),
    .last_i      (last),
    .idx_valid_i (idx_valid_i),
    .idx_data_i  (idx_data_i),
    .idx_ready_o (idx_ready_o),
    .valid_o     (req_valid_o),
    .addr_o      (req_addr_o)
  );

  // R7
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !req_valid_o);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!req_valid_o && !idx_ready_o));

  // R5
  run_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> run);
endmodule

// File: tb/vec_agen_tb_top.sv
`timescale 1ns/1ps
module vec_agen_tb_top;
  localparam int AW = 16;
  localparam int VW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [1:0]    mode_i;
  logic [AW-1:0] base_i, stride_i, idx_data_i;
  logic [VW-1:0] vl_i;
  logic          idx_valid_i, idx_ready_o;
  logic          req_valid_o, req_ready_i;
  logic [VW-1:0] req_elem_o;
  logic [AW-1:0] req_addr_o;
  logic          done_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  vec_agen #(.ADDR_W(AW), .VL_W(VW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .base_i(base_i), .stride_i(stride_i), .vl_i(vl_i),
    .idx_valid_i(idx_valid_i), .idx_data_i(idx_data_i), .idx_ready_o(idx_ready_o),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .req_elem_o(req_elem_o), .req_addr_o(req_addr_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  function automatic logic [AW-1:0] idx_val(input int k, input int salt);
    return AW'(k * 29 + salt * 7 + 5);
  endfunction

  function automatic logic [AW-1:0] exp_addr(input int md, input logic [AW-1:0] b,
                                             input logic [AW-1:0] s, input int n, input int salt);
    if (md == 2) return b + idx_val(n, salt);
    if (md == 1) return b + AW'(n) * s;
    return b + AW'(n);
  endfunction

  function automatic logic [15:0] step_lfsr(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // One complete run; stall=1 gives a stalling consumer and index source.
  task automatic run_vec(input int md, input logic [AW-1:0] b, input logic [AW-1:0] s,
                         input int vl, input bit stall, input int salt, input bit inject);
    int n = 0;
    int sent = 0;
    int cyc = 0;
    bit expect_done = 0;
    bit prev_valid = 0, prev_ready = 0;
    logic [AW-1:0] prev_addr = '0;
    logic [VW-1:0] prev_elem = '0;
    string rq;
    rq = (md == 2) ? "R4" : (md == 1) ? "R3" : (md == 3) ? "R10" : "R2";
    @(negedge clk);
    start_i = 1'b1; mode_i = 2'(md); base_i = b; stride_i = s; vl_i = VW'(vl);
    @(negedge clk);
    start_i = 1'b0;
    if (vl == 0) begin
      // R8: done due the cycle after start, no request
      check(done_o === 1'b1, "R8", "done after zero VL", done_o, 1);
      check(req_valid_o === 1'b0, "R8", "no request on zero VL", req_valid_o, 0);
    end else if (md != 2) begin
      check(req_valid_o === 1'b1, rq, "first request one cycle after start", req_valid_o, 1);
    end
    forever begin
      if (prev_valid && !prev_ready) begin
        // R6: stalled request held
        check(req_valid_o === 1'b1 && req_addr_o === prev_addr && req_elem_o === prev_elem,
              "R6", "held request", req_addr_o, prev_addr);
      end
      if (idx_ready_o === 1'b1 && (md != 2 || req_valid_o !== 1'b0))
        check(1'b0, "R4", "idx_ready outside indexed gap", idx_ready_o, 0);
      if (expect_done)
        check(done_o === 1'b1, "R7", "done after final request", done_o, 1);
      if (done_o === 1'b1) begin
        check(n == vl, "R5", "request count at done", n, vl);
        check(req_valid_o === 1'b0, "R7", "no request with done", req_valid_o, 0);
        break;
      end
      if (expect_done) break;
      lfsr = step_lfsr(lfsr);
      req_ready_i = stall ? (lfsr[0] | lfsr[3]) : 1'b1;
      idx_valid_i = stall ? (lfsr[5] | lfsr[7]) : 1'b1;
      idx_data_i  = idx_val(sent, salt);
      start_i     = inject && (cyc == 2);
      base_i      = inject ? b + 16'h0100 : b;
      vl_i        = inject ? VW'(vl + 3) : VW'(vl);
      if (req_valid_o === 1'b1 && req_ready_i) begin
        check(req_addr_o === exp_addr(md, b, s, n, salt), rq, "request address",
              req_addr_o, exp_addr(md, b, s, n, salt));
        check(req_elem_o === VW'(n), "R5", "element number", req_elem_o, n);
        n++;
        if (n == vl) expect_done = 1;
        if (n > vl) begin
          check(1'b0, "R5", "excess request", n, vl);
          break;
        end
      end
      if (idx_ready_o === 1'b1 && idx_valid_i) sent++;
      prev_valid = (req_valid_o === 1'b1);
      prev_ready = req_ready_i;
      prev_addr  = req_addr_o;
      prev_elem  = req_elem_o;
      cyc++;
      if (cyc > 300) begin
        check(1'b0, rq, "run timed out", n, vl);
        break;
      end
      @(negedge clk);
    end
    start_i = 1'b0; req_ready_i = 1'b0; idx_valid_i = 1'b0;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      // R7 and R9: quiet afterwards, no second run from an ignored start
      check(done_o === 1'b0 && req_valid_o === 1'b0 && idx_ready_o === 1'b0,
            inject ? "R9" : "R7", "idle after done", {done_o, req_valid_o, idx_ready_o}, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R5", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; mode_i = '0; base_i = '0; stride_i = '0;
    vl_i = '0; idx_valid_i = 1'b0; idx_data_i = '0; req_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(req_valid_o === 1'b0 && done_o === 1'b0 && idx_ready_o === 1'b0,
          "R1", "outputs in reset", {req_valid_o, done_o, idx_ready_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(req_valid_o === 1'b0 && done_o === 1'b0 && idx_ready_o === 1'b0,
          "R1", "outputs after reset", {req_valid_o, done_o, idx_ready_o}, 0);

    // Sweep: every mode code, VL 0..17, three strides, two consumer patterns
    for (int md = 0; md < 4; md++)
      for (int vl = 0; vl < 18; vl++)
        for (int si = 0; si < 3; si++)
          for (int st = 0; st < 2; st++) begin
            logic [AW-1:0] b, s;
            b = (si == 2) ? 16'hFFF0 : AW'(16'h1000 + vl * 3 + md);
            s = (si == 0) ? 16'd4 : (si == 1) ? 16'hFFFD : 16'd7;
            run_vec(md, b, s, vl, st[0], md * 64 + vl * 3 + si, 1'b0);
          end

    // R9: start pulses while busy are ignored
    for (int md = 0; md < 3; md++)
      run_vec(md, 16'h2200, 16'd5, 6, 1'b1, 11 + md, 1'b1);
    run_vec(1, 16'h3000, 16'd2, 1, 1'b0, 3, 1'b1);

    summary();
    $finish;
  end
endmodule